// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is a single timer channel built around a down-counter and a reload constant. While the run bit is set, the counter steps down by one on every count tick. A tick comes either from an internal prescaler that divides the block clock, or from a chosen edge of an external event input. When a tick arrives with the counter at zero, the counter takes the reload constant and an underflow flag is set. Counting then goes on without software help, so the channel produces a periodic event.

A second external input can capture the current count into a capture register. That capture also sets its own flag. Both flags are sticky. A single level interrupt stays high while either flag is set with its enable on. Software clears a flag by writing 0 to its bit.

Software reaches the channel through a flat register port. A write strobe carries an address and data, and read data is chosen combinationally by the same address. Software normally sets the control fields, the constant and an initial count, then sets the run bit.

Top module: `reload_timer_channel`

## Requirements
- R1: After reset, all registers (control, constant, count, capture, run) read as zero and `irq` is low.
- R2: While the run bit (address 4, bit 0) is 0, the count register keeps its value. A software write to the count (address 2) loads that value, and this write takes priority over a count tick in the same cycle.
- R3: On each count tick while running, a nonzero count drops by one. A tick with the count at zero loads the constant (address 1) and sets the underflow flag (control bit 8) in the same step.
- R4: Control bits [2:0] pick the tick source: 000 divides the clock by 4, 001 by 16, 010 by 64, 011 by 256, 100 by 1024, 101 selects the external clock input, and 110/111 act as divide-by-4. The prescaler is held cleared while not running, so with divisor D and initial count N the first underflow flag shows D*(N+1) cycles after the edge that sets the run bit.
- R5: With the external source selected, control bits [4:3] pick the counting edge of the synchronized external input: 00 rising, 01 falling, 1x both.
- R6: When capture is enabled (control bit 6), a rising edge on `cap_in` copies the count into the read-only capture register (address 3) and sets the capture flag (control bit 9). When capture is disabled, the capture register and the capture flag do not change.
- R7: `irq` is high exactly while (underflow flag and underflow enable, bit 5) or (capture flag and capture enable, bit 7) holds. With both enables at 0 it stays low even when the flags are set.
- R8: A flag stays set until a control write carries 0 in its bit position. Writing 1 there leaves it unchanged. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and five prescaler stages of divide-by-4 each. Small initial counts bring the underflow after every divisor up to 1024 within a few thousand cycles. That makes the exact cycle of the first flag measurable for each select code, including a reserved one. Short pulse trains on the external input reach all three edge modes, and a held count gives a known capture value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register addresses
    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_CONST = 3'd1;
    localparam logic [2:0] ADR_COUNT = 3'd2;
    localparam logic [2:0] ADR_CAPT  = 3'd3;
    localparam logic [2:0] ADR_RUN   = 3'd4;

    // control bit positions
    localparam int B_UIE  = 5;
    localparam int B_CEN  = 6;
    localparam int B_CIE  = 7;
    localparam int B_UF   = 8;
    localparam int B_CF   = 9;

    localparam logic [2:0] SRC_EXT = 3'b101;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_BTH2 = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int NUM_DIV  = 5,
    parameter int LOG_STEP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PRE_W = NUM_DIV * LOG_STEP;

    logic [PRE_W-1:0]   pre_d, pre_q;
    logic [NUM_DIV-1:0] taps;
    logic [2:0]         idx;

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
        assign taps[k] = &pre_q[(k+1)*LOG_STEP-1:0];
    end

    always_comb begin
        pre_d = run ? pre_q + 1'b1 : '0;
        idx   = (32'(sel) < NUM_DIV) ? sel : 3'd0;
        tick  = taps[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_in};
        prev_d = sync_q[STAGES-1];
        rise   =  sync_q[STAGES-1] & ~prev_q;
        fall   = ~sync_q[STAGES-1] &  prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/reload_timer_channel.sv
module reload_timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_DIV  = 5,
    parameter int LOG_STEP = 2,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_clk_in,
    input  logic             cap_in,
    output logic             irq
);
    typedef struct packed {
        logic [2:0]       src;
        edge_sel_e        edg;
        logic             uie;
        logic             cen;
        logic             cie;
        logic             uf;
        logic             cf;
        logic             run;
        logic [CNT_W-1:0] cst;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
    } state_t;

    state_t s_d, s_q;

    logic pre_tick, ext_rise, ext_fall, cap_rise, cap_fall;
    logic ext_tick, count_en, cnt_wr, ctrl_wr;

    tmr_prescaler #(.NUM_DIV(NUM_DIV), .LOG_STEP(LOG_STEP)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (s_q.run),
        .sel (s_q.src),
        .tick(pre_tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_N)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .async_in(ext_clk_in),
        .rise    (ext_rise),
        .fall    (ext_fall)
    );

    tmr_edge_sync #(.STAGES(SYNC_N)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .async_in(cap_in),
        .rise    (cap_rise),
        .fall    (cap_fall)
    );

    always_comb begin
        unique case (s_q.edg)
            EDGE_RISE: ext_tick = ext_rise;
            EDGE_FALL: ext_tick = ext_fall;
            default:   ext_tick = ext_rise | ext_fall;
        endcase
        count_en = s_q.run && ((s_q.src == SRC_EXT) ? ext_tick : pre_tick);
        cnt_wr   = wr_en && (addr == ADR_COUNT);
        ctrl_wr  = wr_en && (addr == ADR_CTRL);
    end

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) begin
            s_d.src = wr_data[2:0];
            s_d.edg = edge_sel_e'(wr_data[4:3]);
            s_d.uie = wr_data[B_UIE];
            s_d.cen = wr_data[B_CEN];
            s_d.cie = wr_data[B_CIE];
            if (!wr_data[B_UF]) s_d.uf = 1'b0;
            if (!wr_data[B_CF]) s_d.cf = 1'b0;
        end
        if (wr_en && addr == ADR_CONST) s_d.cst = wr_data;
        if (wr_en && addr == ADR_RUN)   s_d.run = wr_data[0];

        if (count_en) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = s_q.cst;
                s_d.uf  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (cnt_wr) s_d.cnt = wr_data;

        if (s_q.cen && cap_rise) begin
            s_d.cap = s_q.cnt;
            s_d.cf  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADR_CTRL: begin
                rd_data[2:0]  = s_q.src;
                rd_data[4:3]  = s_q.edg;
                rd_data[B_UIE] = s_q.uie;
                rd_data[B_CEN] = s_q.cen;
                rd_data[B_CIE] = s_q.cie;
                rd_data[B_UF]  = s_q.uf;
                rd_data[B_CF]  = s_q.cf;
            end
            ADR_CONST: rd_data = s_q.cst;
            ADR_COUNT: rd_data = s_q.cnt;
            ADR_CAPT:  rd_data = s_q.cap;
            ADR_RUN:   rd_data[0] = s_q.run;
            default:   rd_data = '0;
        endcase
        irq = (s_q.uf & s_q.uie) | (s_q.cf & s_q.cie);
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             run_q,
    input logic             count_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cst_q,
    input logic [CNT_W-1:0] cap_q,
    input logic             cen_q,
    input logic             uf_q,
    input logic             uie_q,
    input logic             cie_q,
    input logic             irq
);
    logic cnt_wr, uf_clr;
    assign cnt_wr = wr_en && addr == 3'd2;
    assign uf_clr = wr_en && addr == 3'd0 && !wr_data[8];

    // R2: stopped counter holds unless software writes it
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_wr) |=> $stable(cnt_q));

    // R3: nonzero count steps down by one
    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (count_en && cnt_q != '0 && !cnt_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: zero count reloads and raises the flag
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (count_en && cnt_q == '0 && !cnt_wr) |=> (cnt_q == $past(cst_q) && uf_q));

    // R8: underflow flag sticky without a clearing write
    a_r8_uf_sticky: assert property (@(posedge clk) disable iff (rst)
        (uf_q && !uf_clr) |=> uf_q);

    // R6: capture register frozen while capture is disabled
    a_r6_cap_frozen: assert property (@(posedge clk) disable iff (rst)
        !cen_q |=> $stable(cap_q));

    // R7: no interrupt with both enables off
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        (!uie_q && !cie_q) |-> !irq);
endmodule

bind reload_timer_channel tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .run_q   (s_q.run),
    .count_en(count_en),
    .cnt_q   (s_q.cnt),
    .cst_q   (s_q.cst),
    .cap_q   (s_q.cap),
    .cen_q   (s_q.cen),
    .uf_q    (s_q.uf),
    .uie_q   (s_q.uie),
    .cie_q   (s_q.cie),
    .irq     (irq)
);

// File: tb/sim_reload_timer_channel.sv
module sim_reload_timer_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ext_clk_in = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    reload_timer_channel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk_in(ext_clk_in), .cap_in(cap_in), .irq(irq)
    );

    // driver side: queue an expectation
    task automatic expect_val(input string tag, input logic [31:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sb.push_back(e);
    endtask

    // monitor side: pop and compare an observed result
    task automatic observe(input logic [31:0] got);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty got=%0h expected=none", got);
            return;
        end
        e = sb.pop_front();
        if (got !== e.val) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", e.tag, got, e.val);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles from the run-setting edge until irq is seen
    task automatic measure_irq(input int limit, output int n);
        n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(input bit is_ext, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk); if (is_ext) ext_clk_in = 1'b1; else cap_in = 1'b1;
            wait_cyc(3);
            @(negedge clk); if (is_ext) ext_clk_in = 1'b0; else cap_in = 1'b0;
            wait_cyc(3);
        end
        wait_cyc(5);
    endtask

    // prescaler case: src code, divisor, initial count
    task automatic div_case(input logic [2:0] src, input int dv, input int n0, input string tag);
        int n;
        wr(3'd4, 32'd0);
        wr(3'd0, {26'd0, 1'b1, 2'b00, src});   // uie=1, clears flags
        wr(3'd2, n0);
        wr(3'd1, 32'd7);
        wr(3'd4, 32'd1);
        measure_irq(5000, n);
        expect_val(tag, dv * (n0 + 1));
        observe(n);
        wr(3'd4, 32'd0);
    endtask

    task automatic ext_case(input logic [1:0] edg, input int pulses, input int exp_cnt, input string tag);
        logic [31:0] d;
        wr(3'd4, 32'd0);
        wr(3'd0, {27'd0, edg, 3'b101});
        wr(3'd2, 32'd20);
        wr(3'd4, 32'd1);
        pulse(1'b1, pulses);
        rd(3'd2, d);
        expect_val(tag, exp_cnt);
        observe(d);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            expect_val("R1 reset register", 32'd0);
            observe(d);
        end
        expect_val("R1 reset irq", 32'd0);
        observe({31'd0, irq});

        // R2 stopped counter holds written value
        wr(3'd2, 32'd5);
        wait_cyc(20);
        rd(3'd2, d);
        expect_val("R2 hold while stopped", 32'd5);
        observe(d);

        // R3/R4 divide-by-4, count 3 -> 16 cycles
        div_case(3'b000, 4, 3, "R4 div4 timing");
        rd(3'd2, d);
        expect_val("R3 reload from constant", 32'd7);
        observe(d);
        rd(3'd0, d);
        expect_val("R3 underflow flag", 32'd1);
        observe({31'd0, d[8]});

        // R8 writing 1 keeps the flag, writing 0 clears it
        wr(3'd0, 32'h0000_0120);
        expect_val("R8 write one keeps flag", 32'd1);
        observe({31'd0, irq});
        wr(3'd0, 32'h0000_0020);
        expect_val("R8 write zero clears flag", 32'd0);
        observe({31'd0, irq});

        div_case(3'b001, 16, 1, "R4 div16 timing");
        div_case(3'b010, 64, 0, "R4 div64 timing");
        div_case(3'b100, 1024, 0, "R4 div1024 timing");
        div_case(3'b110, 4, 1, "R4 reserved code div4");

        // R7 flag set with enable off -> irq low
        wr(3'd4, 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd0);
        wr(3'd4, 32'd1);
        wait_cyc(10);
        wr(3'd4, 32'd0);
        rd(3'd0, d);
        expect_val("R7 flag set without enable", 32'd1);
        observe({31'd0, d[8]});
        expect_val("R7 irq masked", 32'd0);
        observe({31'd0, irq});

        // R5 external clock edges, 3 pulses from count 20
        ext_case(2'b00, 3, 17, "R5 rising edges");
        ext_case(2'b01, 3, 17, "R5 falling edges");
        ext_case(2'b10, 3, 14, "R5 both edges");
        wr(3'd4, 32'd0);

        // R6 capture disabled: nothing captured
        wr(3'd0, 32'd0);
        wr(3'd2, 32'h1234);
        pulse(1'b0, 1);
        rd(3'd3, d);
        expect_val("R6 no capture when disabled", 32'd0);
        observe(d);
        rd(3'd0, d);
        expect_val("R6 no capture flag when disabled", 32'd0);
        observe({31'd0, d[9]});

        // R6/R7 capture enabled with interrupt
        wr(3'd0, 32'h0000_00C0);
        pulse(1'b0, 1);
        rd(3'd3, d);
        expect_val("R6 captured count", 32'h1234);
        observe(d);
        expect_val("R7 capture irq", 32'd1);
        observe({31'd0, irq});
        wr(3'd0, 32'h0000_00C0);
        expect_val("R8 capture flag cleared", 32'd0);
        observe({31'd0, irq});

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items expected=0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule